// File: doc/BRIEF.md
# Dual-Mode Decrementer Interrupt Timer

This block is a down-counting timer register for an embedded core. Software loads a start value through a one-cycle write strobe. After that the count drops by one on every cycle where the timebase tick enable is high. A 2-bit mode input selects the interrupt policy. There are three policies:

- **Sign-crossing edge mode.** The block flags an interrupt when the value goes from non-negative to negative, and the count keeps running.
- **Zero-stop mode.** The block flags an interrupt when the value reaches zero, and the count then freezes at zero.
- **Level mode.** The interrupt simply follows the sign bit of the count.

The current count and the interrupt status can be read at any time. The edge-style status is sticky and is cleared by an acknowledge pulse. The count, the status and the interrupt line are all registered. They change together, on the clock edge that ends the cycle carrying the write or the tick.

Top module: `dectmr_top`

## Requirements
- R1: After a synchronous reset, rd_value is 0, and both rd_irq_status and irq are 0. The irq output always equals rd_irq_status.
- R2: A cycle with wr_en high loads wr_data, visible on rd_value after that clock edge. The write wins over a tick in the same cycle.
- R3: Without a write, the count drops by exactly one (modulo 2^WIDTH) after a cycle with tick_en high. It holds after a cycle with tick_en low.
- R4: In mode 2'b00, and in mode 2'b11 which behaves the same, a tick that takes the count from a value with MSB 0 to a value with MSB 1 sets the status in the same edge as the count. This happens only for 0 to all-ones. Further ticks keep decrementing.
- R5: In mode 2'b01, a tick that takes the count from 1 to 0 sets the status. While the count is 0, ticks leave it at 0.
- R6: In mode 2'b01, writing a nonzero value to a count stopped at 0 makes later ticks decrement again. Writing 0 leaves it stopped.
- R7: A register write never sets the status in modes 2'b00, 2'b01 or 2'b11, whatever value is written.
- R8: In modes 2'b00, 2'b01 and 2'b11, the status stays set until a cycle with irq_ack high clears it. If a trigger event and irq_ack occur in the same cycle, the status ends up set.
- R9: In mode 2'b10, the status equals the MSB of the count after each edge, and irq_ack has no effect.
- R10: Changing the mode input never changes the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick; decrement permitted this cycle |
| wr_en | input | 1 | Write strobe for the count register |
| wr_data | input | WIDTH | Value to load |
| mode | input | 2 | 00 sign-edge, 01 zero-stop, 10 sign-level, 11 as 00 |
| irq_ack | input | 1 | Clears the sticky status in edge modes |
| rd_value | output | WIDTH | Current count |
| rd_irq_status | output | 1 | Current interrupt status |
| irq | output | 1 | Interrupt request line |

## Verification
Several properties are checked on every cycle:
- Loading a write, holding without a tick, and decrementing by exactly one on a tick.
- Freezing at zero in zero-stop mode.
- The level status tracking the sign bit.
- The sticky status persisting until acknowledged, and the acknowledge clearing it when no event coincides.
- A sign-crossing event producing a negative count with the status set.

The directed scenarios are needed for the rest:
- That writes of negative values or zero raise nothing.
- That reserved mode 11 matches sign-edge mode.
- That a restart happens after a nonzero write.
- That an event coinciding with an acknowledge wins.
- That mode switches leave the count intact.

// File: rtl/dectmr_pkg.sv
package dectmr_pkg;

  typedef enum logic [1:0] {
    MODE_SIGN_EDGE  = 2'b00,
    MODE_ZERO_STOP  = 2'b01,
    MODE_SIGN_LEVEL = 2'b10,
    MODE_RESERVED   = 2'b11
  } dectmr_mode_e;

endpackage

// File: rtl/dectmr_counter.sv
module dectmr_counter #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             tick_en,
  input  logic             stop_at_zero,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_d,
  output logic             dec_fire
);

  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic frozen;

  assign frozen   = stop_at_zero && (cnt_q == ZERO);
  assign dec_fire = tick_en && !wr_en && !frozen;

  always_comb begin
    if (wr_en)         cnt_d = wr_data;
    else if (dec_fire) cnt_d = cnt_q - ONE;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ZERO;
    else     cnt_q <= cnt_d;
  end

  // R2: a write lands on the next edge
  assert_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (cnt_q == $past(wr_data)));

  // R3: no tick, no write -> hold
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick_en) |=> $stable(cnt_q));

  // R3: tick on a running counter decrements by one
  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && tick_en && !(stop_at_zero && cnt_q == ZERO))
      |=> (cnt_q == $past(cnt_q) - ONE));

  // R5: zero-stop freezes at zero
  assert_zero_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    (stop_at_zero && cnt_q == ZERO && !wr_en) |=> (cnt_q == ZERO));

endmodule

// File: rtl/dectmr_event.sv
module dectmr_event
  import dectmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cnt_q,
  input  logic             dec_fire,
  input  dectmr_mode_e     mode,
  output logic             edge_evt
);

  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_minus;
  logic             sign_cross;
  logic             hit_zero;

  assign cnt_minus  = cnt_q - ONE;
  assign sign_cross = dec_fire && !cnt_q[MSB] && cnt_minus[MSB];
  assign hit_zero   = dec_fire && (cnt_q == ONE);

  always_comb begin
    unique case (mode)
      MODE_ZERO_STOP:  edge_evt = hit_zero;
      MODE_SIGN_LEVEL: edge_evt = 1'b0;
      default:         edge_evt = sign_cross;
    endcase
  end

endmodule

// File: rtl/dectmr_irq.sv
module dectmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic level_mode,
  input  logic edge_evt,
  input  logic irq_ack,
  input  logic next_msb,
  input  logic cur_msb,
  output logic flag_q
);

  logic flag_d;

  always_comb begin
    if (level_mode) flag_d = next_msb;
    else            flag_d = edge_evt || (flag_q && !irq_ack);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

  // R9: level status follows sign bit
  assert_level_tracks_msb_R9: assert property (@(posedge clk) disable iff (rst)
    level_mode |=> (flag_q == cur_msb));

  // R8: sticky until acknowledged
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && flag_q && !irq_ack) |=> flag_q);

  // R8: acknowledge clears when no event coincides
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (!level_mode && irq_ack && !edge_evt) |=> !flag_q);

endmodule

// File: rtl/dectmr_top.sv
module dectmr_top
  import dectmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       mode,
  input  logic             irq_ack,
  output logic [WIDTH-1:0] rd_value,
  output logic             rd_irq_status,
  output logic             irq
);

  localparam int MSB = WIDTH - 1;

  dectmr_mode_e     mode_sel;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             dec_fire;
  logic             edge_evt;
  logic             flag_q;

  assign mode_sel = dectmr_mode_e'(mode);

  dectmr_counter #(.WIDTH(WIDTH)) u_counter (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .tick_en      (tick_en),
    .stop_at_zero (mode_sel == MODE_ZERO_STOP),
    .cnt_q        (cnt_q),
    .cnt_d        (cnt_d),
    .dec_fire     (dec_fire)
  );

  dectmr_event #(.WIDTH(WIDTH)) u_event (
    .cnt_q    (cnt_q),
    .dec_fire (dec_fire),
    .mode     (mode_sel),
    .edge_evt (edge_evt)
  );

  dectmr_irq u_irq (
    .clk        (clk),
    .rst        (rst),
    .level_mode (mode_sel == MODE_SIGN_LEVEL),
    .edge_evt   (edge_evt),
    .irq_ack    (irq_ack),
    .next_msb   (cnt_d[MSB]),
    .cur_msb    (cnt_q[MSB]),
    .flag_q     (flag_q)
  );

  assign rd_value      = cnt_q;
  assign rd_irq_status = flag_q;
  assign irq           = flag_q;

  // R4: a sign-crossing event leaves a negative count with status raised
  assert_cross_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == MODE_SIGN_EDGE || mode_sel == MODE_RESERVED) && edge_evt)
      |=> (rd_value[MSB] && rd_irq_status));

endmodule

// File: tb/dectmr_top_tb.sv
module dectmr_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst;
  logic         tick_en, wr_en, irq_ack;
  logic [W-1:0] wr_data;
  logic [1:0]   mode;
  logic [W-1:0] rd_value;
  logic         rd_irq_status, irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dectmr_top #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
    .mode(mode), .irq_ack(irq_ack), .rd_value(rd_value),
    .rd_irq_status(rd_irq_status), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input logic [W-1:0] val, input logic st);
    check(req, rd_value, val);
    check(req, {31'b0, rd_irq_status}, {31'b0, st});
    check(req, {31'b0, irq}, {31'b0, st});
  endtask

  // one clock: drive at negedge, sample just after posedge
  task automatic cyc(input logic w, input logic [W-1:0] d, input logic t, input logic a);
    @(negedge clk);
    wr_en = w; wr_data = d; tick_en = t; irq_ack = a;
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
  endtask

  task automatic t_reset;
    check_out("R1", 32'h0, 1'b0);
  endtask

  task automatic t_write_and_tick;
    set_mode(2'b00);
    cyc(1, 32'd5, 1, 0);   check_out("R2", 32'd5, 0);
    cyc(0, 0, 1, 0);       check_out("R3", 32'd4, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);       check_out("R3", 32'd2, 0);
    cyc(0, 0, 0, 0);       check_out("R3", 32'd2, 0);
  endtask

  task automatic t_underflow;
    set_mode(2'b00);
    cyc(1, 32'd1, 0, 0);   check_out("R4", 32'd1, 0);
    cyc(0, 0, 1, 0);       check_out("R4", 32'd0, 0);
    cyc(0, 0, 1, 0);       check_out("R4", 32'hFFFF_FFFF, 1);
    cyc(0, 0, 1, 0);       check_out("R4", 32'hFFFF_FFFE, 1);
    cyc(0, 0, 0, 0);       check_out("R8", 32'hFFFF_FFFE, 1);
    cyc(0, 0, 0, 1);       check_out("R8", 32'hFFFF_FFFE, 0);
    set_mode(2'b11);
    cyc(1, 32'd0, 0, 0);   check_out("R4", 32'd0, 0);
    cyc(0, 0, 1, 0);       check_out("R4", 32'hFFFF_FFFF, 1);
    cyc(0, 0, 0, 1);       check_out("R8", 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_write_no_irq;
    set_mode(2'b00);
    cyc(1, 32'h8000_0000, 0, 0); check_out("R7", 32'h8000_0000, 0);
    cyc(1, 32'hFFFF_FFFF, 1, 0); check_out("R7", 32'hFFFF_FFFF, 0);
    set_mode(2'b01);
    cyc(1, 32'd0, 0, 0);         check_out("R7", 32'd0, 0);
  endtask

  task automatic t_zero_stop;
    set_mode(2'b01);
    cyc(1, 32'd2, 0, 0);   check_out("R5", 32'd2, 0);
    cyc(0, 0, 1, 0);       check_out("R5", 32'd1, 0);
    cyc(0, 0, 1, 0);       check_out("R5", 32'd0, 1);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);       check_out("R5", 32'd0, 1);
    cyc(0, 0, 1, 1);       check_out("R8", 32'd0, 0);
    cyc(1, 32'd0, 0, 0);
    cyc(0, 0, 1, 0);       check_out("R6", 32'd0, 0);
    cyc(1, 32'd3, 0, 0);
    cyc(0, 0, 1, 0);       check_out("R6", 32'd2, 0);
  endtask

  task automatic t_ack_collide;
    set_mode(2'b00);
    cyc(1, 32'd0, 0, 0);
    cyc(0, 0, 1, 0);       check_out("R8", 32'hFFFF_FFFF, 1);
    cyc(1, 32'd0, 0, 0);   check_out("R8", 32'd0, 1);
    cyc(0, 0, 1, 1);       check_out("R8", 32'hFFFF_FFFF, 1);
    cyc(0, 0, 0, 1);       check_out("R8", 32'hFFFF_FFFF, 0);
  endtask

  task automatic t_level;
    set_mode(2'b10);
    cyc(1, 32'd1, 0, 0);   check_out("R9", 32'd1, 0);
    cyc(0, 0, 1, 0);       check_out("R9", 32'd0, 0);
    cyc(0, 0, 1, 0);       check_out("R9", 32'hFFFF_FFFF, 1);
    cyc(0, 0, 0, 1);       check_out("R9", 32'hFFFF_FFFF, 1);
    cyc(1, 32'd5, 0, 0);   check_out("R9", 32'd5, 0);
  endtask

  task automatic t_mode_change;
    set_mode(2'b00);
    cyc(1, 32'h1234, 0, 0);
    set_mode(2'b01);
    cyc(0, 0, 0, 0);       check_out("R10", 32'h1234, 0);
    set_mode(2'b10);
    cyc(0, 0, 0, 0);       check_out("R10", 32'h1234, 0);
    set_mode(2'b11);
    cyc(0, 0, 0, 0);       check_out("R10", 32'h1234, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; tick_en = 0; wr_en = 0; irq_ack = 0; wr_data = '0; mode = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_write_and_tick();
    t_underflow();
    t_write_no_irq();
    t_zero_stop();
    t_ack_collide();
    t_level();
    t_mode_change();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule